// File: doc/BRIEF.md
# Scatter-Gather DMA Descriptor Engine

This block drains acquired sample words from a local staging FIFO and writes them into host memory. Software arms it with a start pulse, choosing one of two modes. In single-block mode the write address and length come straight from configuration inputs, and the length is capped. In chained mode the engine walks a list of descriptors that sit in host memory, starting from a head pointer. Each descriptor points at one buffer, so non-contiguous buffers are filled back to back. The list may end with a null link, or it may close on itself to form a ring that repeats until software stops it.

After the start pulse the engine waits for the acquisition trigger before it touches memory. Descriptors are read one 32-bit word at a time through a request/response read port. Data words leave through a write port with a valid/ready handshake; the FIFO pop is that handshake, so a stall on either side loses no word. Sticky done and error flags report how the last run ended.

Top module: `sg_dma_engine`

## Requirements
- R1: While reset is low and right after it is released, `busy`, `doneFlag`, `errFlag`, `wrValid`, `rdReqValid` and `fifoPop` are all 0.
- R2: After an accepted start, the engine is busy but issues no descriptor read and no data write until `trigIn` is seen high.
- R3: In single-block mode (`cfgChainMode`=0) with length N, the engine writes exactly N words to `cfgBlkAddr`, `cfgBlkAddr`+4, and onward, using the full 64-bit address with carry. The words go out in FIFO order, and then `doneFlag` is set and `busy` drops.
- R4: In single-block mode a length above 2097152 words sets `errFlag` on the cycle after the start, with no transfer and no busy period. A length of exactly 2097152 is accepted.
- R5: In single-block mode a length of 0 sets `doneFlag` without any write.
- R6: A descriptor is four 32-bit words read in this order from ptr, ptr+4, ptr+8, ptr+12: buffer address bits 31:0, buffer address bits 63:32, size in 32-bit words, next-descriptor pointer. Only one read is outstanding at a time.
- R7: In chained mode (`cfgChainMode`=1) the engine starts at `cfgHeadPtr`, fills each buffer in turn, and follows the next pointers. After a descriptor whose next pointer is 0, it sets `doneFlag`.
- R8: A descriptor with size 0 produces no write; the engine goes on to its next pointer.
- R9: When the FIFO shows no valid word or `wrReady` is low, the write stalls. No word is lost or duplicated, and the write address holds until the word is accepted.
- R10: A circular list repeats without end. A `cfgStop` pulse lets a word in handshake that cycle complete, then returns the engine to idle with `doneFlag` set, and no further write follows.
- R11: A start pulse while busy is ignored.
- R12: `doneFlag` and `errFlag` hold their value until the next accepted start, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgStart | input | 1 | Start pulse, taken only when idle |
| cfgStop | input | 1 | Stop pulse |
| cfgChainMode | input | 1 | 1 = follow descriptor chain, 0 = single block |
| cfgHeadPtr | input | 32 | Address of the first descriptor |
| cfgBlkAddr | input | 64 | Single-block destination address |
| cfgBlkLen | input | 32 | Single-block length in 32-bit words |
| trigIn | input | 1 | Acquisition trigger |
| fifoValid | input | 1 | Staging FIFO holds a word |
| fifoData | input | 32 | Head word of the staging FIFO |
| fifoPop | output | 1 | Removes the head word |
| rdReqValid | output | 1 | Descriptor read request |
| rdReqAddr | output | 32 | Descriptor word address |
| rdReqReady | input | 1 | Read request accepted |
| rdRspValid | input | 1 | Read data valid |
| rdRspData | input | 32 | Read data |
| wrValid | output | 1 | Data write valid |
| wrAddr | output | 64 | Data write byte address |
| wrData | output | 32 | Data write word |
| wrReady | input | 1 | Data write accepted |
| busy | output | 1 | Engine not idle |
| doneFlag | output | 1 | Sticky completion flag |
| errFlag | output | 1 | Sticky oversize-length flag |

## Verification
A single block at a 64-bit address with a delayed trigger checks that nothing moves before the trigger and that the addresses step correctly. Zero, oversize and exactly-at-cap lengths check the boundary of the size check. A three-descriptor chain, with a zero-size link in the middle and a buffer that crosses a 4 GB boundary, runs under random FIFO and ready stalls. It shows whether field order, skipping, address carry and the handshake hold up under back-pressure. A two-descriptor ring stopped after several laps separates correct wrap-around and a clean stop from overrun. A start pulse sent while busy shows whether the engine ignores it.

// File: rtl/sg_dma_pkg.sv
package sg_dma_pkg;

  localparam int DESC_WORDS  = 4;
  localparam int FLD_ADDR_LO = 0;
  localparam int FLD_ADDR_HI = 1;
  localparam int FLD_SIZE    = 2;
  localparam int FLD_NEXT    = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARMED,
    ST_FETCH,
    ST_EVAL,
    ST_XFER,
    ST_FINISH
  } dma_state_e;

  typedef struct packed {
    logic loadSingle;
    logic loadHead;
    logic loadNext;
    logic fetchCapture;
    logic beginDesc;
    logic xferEn;
  } dma_ctl_t;

  typedef struct packed {
    logic accept;
    logic remOne;
    logic fetchLast;
    logic sizeZero;
    logic nextZero;
  } dma_sts_t;

endpackage

// File: rtl/sg_dma_path.sv
module sg_dma_path
  import sg_dma_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int PTR_W  = 32,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dma_ctl_t          ctl,
  output dma_sts_t          sts,
  input  logic [PTR_W-1:0]  cfgHeadPtr,
  input  logic [ADDR_W-1:0] cfgBlkAddr,
  input  logic [LEN_W-1:0]  cfgBlkLen,
  output logic [PTR_W-1:0]  rdReqAddr,
  input  logic [DATA_W-1:0] rdRspData,
  input  logic              fifoValid,
  input  logic [DATA_W-1:0] fifoData,
  output logic              fifoPop,
  output logic              wrValid,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  input  logic              wrReady
);

  localparam int IDX_W     = $clog2(DESC_WORDS);
  localparam int BYTE_SH   = $clog2(DATA_W / 8);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DATA_W / 8);

  logic [PTR_W-1:0]  descPtr;
  logic [IDX_W-1:0]  fetchIdx;
  logic [DATA_W-1:0] descWord [DESC_WORDS];
  logic [ADDR_W-1:0] curAddr;
  logic [LEN_W-1:0]  remaining;
  logic              remZero;
  logic              accept;

  assign remZero   = (remaining == '0);
  assign wrValid   = ctl.xferEn && fifoValid && !remZero;
  assign accept    = wrValid && wrReady;
  assign fifoPop   = accept;
  assign wrAddr    = curAddr;
  assign wrData    = fifoData;
  assign rdReqAddr = descPtr + (PTR_W'(fetchIdx) << BYTE_SH);

  assign sts.accept    = accept;
  assign sts.remOne    = (remaining == LEN_W'(1));
  assign sts.fetchLast = (fetchIdx == IDX_W'(DESC_WORDS - 1));
  assign sts.sizeZero  = (descWord[FLD_SIZE] == '0);
  assign sts.nextZero  = (descWord[FLD_NEXT] == '0);

  // descriptor pointer and word index
  always_ff @(posedge clk) begin
    if (!rstN) begin
      descPtr  <= '0;
      fetchIdx <= '0;
    end else if (ctl.loadHead) begin
      descPtr  <= cfgHeadPtr;
      fetchIdx <= '0;
    end else if (ctl.loadNext) begin
      descPtr  <= PTR_W'(descWord[FLD_NEXT]);
      fetchIdx <= '0;
    end else if (ctl.fetchCapture) begin
      fetchIdx <= fetchIdx + IDX_W'(1);
    end
  end

  // descriptor word capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DESC_WORDS; i++) descWord[i] <= '0;
    end else if (ctl.fetchCapture) begin
      for (int i = 0; i < DESC_WORDS; i++)
        if (fetchIdx == IDX_W'(i)) descWord[i] <= rdRspData;
    end
  end

  // write address and remaining count
  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr   <= '0;
      remaining <= '0;
    end else if (ctl.loadSingle) begin
      curAddr   <= cfgBlkAddr;
      remaining <= cfgBlkLen;
    end else if (ctl.beginDesc) begin
      curAddr   <= ADDR_W'({descWord[FLD_ADDR_HI], descWord[FLD_ADDR_LO]});
      remaining <= LEN_W'(descWord[FLD_SIZE]);
    end else if (accept) begin
      curAddr   <= curAddr + STEP;
      remaining <= remaining - LEN_W'(1);
    end
  end

  assert_addr_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!accept && !ctl.beginDesc && !ctl.loadSingle) |=> $stable(curAddr));

  assert_no_write_past_end_R3: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> ($past(remaining) != '0));

endmodule

// File: rtl/sg_dma_ctrl.sv
module sg_dma_ctrl
  import sg_dma_pkg::*;
#(
  parameter int LEN_W         = 32,
  parameter int MAX_SINGLE_DW = 2097152
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgStart,
  input  logic             cfgStop,
  input  logic             cfgChainMode,
  input  logic [LEN_W-1:0] cfgBlkLen,
  input  logic             trigIn,
  input  logic             rdReqReady,
  input  logic             rdRspValid,
  input  dma_sts_t         sts,
  output dma_ctl_t         ctl,
  output logic             rdReqValid,
  output logic             busy,
  output logic             doneFlag,
  output logic             errFlag
);

  localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(MAX_SINGLE_DW);

  dma_state_e state, nextState;
  logic       chainMode;
  logic       rdPending;
  logic       errSet;
  logic       startTaken;

  assign busy       = (state != ST_IDLE);
  assign startTaken = (state == ST_IDLE) && cfgStart;

  always_comb begin
    nextState  = state;
    ctl        = '0;
    rdReqValid = 1'b0;
    errSet     = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (cfgStart) begin
          if (cfgChainMode) begin
            ctl.loadHead = 1'b1;
            nextState    = ST_ARMED;
          end else if (cfgBlkLen > MAX_LEN) begin
            errSet = 1'b1;
          end else if (cfgBlkLen == '0) begin
            nextState = ST_FINISH;
          end else begin
            ctl.loadSingle = 1'b1;
            nextState      = ST_ARMED;
          end
        end
      end
      ST_ARMED: begin
        if (cfgStop)     nextState = ST_FINISH;
        else if (trigIn) nextState = chainMode ? ST_FETCH : ST_XFER;
      end
      ST_FETCH: begin
        rdReqValid = !rdPending;
        if (cfgStop) begin
          nextState = ST_FINISH;
        end else if (rdPending && rdRspValid) begin
          ctl.fetchCapture = 1'b1;
          if (sts.fetchLast) nextState = ST_EVAL;
        end
      end
      ST_EVAL: begin
        if (cfgStop) begin
          nextState = ST_FINISH;
        end else if (sts.sizeZero) begin
          if (sts.nextZero) begin
            nextState = ST_FINISH;
          end else begin
            ctl.loadNext = 1'b1;
            nextState    = ST_FETCH;
          end
        end else begin
          ctl.beginDesc = 1'b1;
          nextState     = ST_XFER;
        end
      end
      ST_XFER: begin
        ctl.xferEn = 1'b1;
        if (cfgStop) begin
          nextState = ST_FINISH;
        end else if (sts.accept && sts.remOne) begin
          if (!chainMode || sts.nextZero) begin
            nextState = ST_FINISH;
          end else begin
            ctl.loadNext = 1'b1;
            nextState    = ST_FETCH;
          end
        end
      end
      ST_FINISH: nextState = ST_IDLE;
      default:   nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      chainMode <= 1'b0;
      rdPending <= 1'b0;
      doneFlag  <= 1'b0;
      errFlag   <= 1'b0;
    end else begin
      state <= nextState;
      if (startTaken) begin
        chainMode <= cfgChainMode;
        doneFlag  <= 1'b0;
        errFlag   <= errSet;
      end else if (state == ST_FINISH) begin
        doneFlag <= 1'b1;
      end
      if (nextState != ST_FETCH)          rdPending <= 1'b0;
      else if (rdReqValid && rdReqReady)  rdPending <= 1'b1;
      else if (ctl.fetchCapture)          rdPending <= 1'b0;
    end
  end

  assert_single_read_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rdReqValid && rdReqReady) |=> !rdReqValid);

  assert_ignore_start_R11: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cfgStart && !cfgStop && state != ST_FINISH) |=> busy);

endmodule

// File: rtl/sg_dma_engine.sv
module sg_dma_engine
  import sg_dma_pkg::*;
#(
  parameter int ADDR_W        = 64,
  parameter int PTR_W         = 32,
  parameter int DATA_W        = 32,
  parameter int LEN_W         = 32,
  parameter int MAX_SINGLE_DW = 2097152
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgStart,
  input  logic              cfgStop,
  input  logic              cfgChainMode,
  input  logic [PTR_W-1:0]  cfgHeadPtr,
  input  logic [ADDR_W-1:0] cfgBlkAddr,
  input  logic [LEN_W-1:0]  cfgBlkLen,
  input  logic              trigIn,
  input  logic              fifoValid,
  input  logic [DATA_W-1:0] fifoData,
  output logic              fifoPop,
  output logic              rdReqValid,
  output logic [PTR_W-1:0]  rdReqAddr,
  input  logic              rdReqReady,
  input  logic              rdRspValid,
  input  logic [DATA_W-1:0] rdRspData,
  output logic              wrValid,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  input  logic              wrReady,
  output logic              busy,
  output logic              doneFlag,
  output logic              errFlag
);

  dma_ctl_t ctl;
  dma_sts_t sts;

  sg_dma_ctrl #(
    .LEN_W(LEN_W), .MAX_SINGLE_DW(MAX_SINGLE_DW)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .cfgStart(cfgStart), .cfgStop(cfgStop),
    .cfgChainMode(cfgChainMode), .cfgBlkLen(cfgBlkLen), .trigIn(trigIn),
    .rdReqReady(rdReqReady), .rdRspValid(rdRspValid), .sts(sts), .ctl(ctl),
    .rdReqValid(rdReqValid), .busy(busy), .doneFlag(doneFlag), .errFlag(errFlag)
  );

  sg_dma_path #(
    .ADDR_W(ADDR_W), .PTR_W(PTR_W), .DATA_W(DATA_W), .LEN_W(LEN_W)
  ) uPath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .sts(sts), .cfgHeadPtr(cfgHeadPtr),
    .cfgBlkAddr(cfgBlkAddr), .cfgBlkLen(cfgBlkLen), .rdReqAddr(rdReqAddr),
    .rdRspData(rdRspData), .fifoValid(fifoValid), .fifoData(fifoData),
    .fifoPop(fifoPop), .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData),
    .wrReady(wrReady)
  );

  assert_write_needs_busy_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid || rdReqValid) |-> busy);

  assert_err_without_run_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFlag) |-> (!busy && !doneFlag));

  assert_done_when_idle_R12: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneFlag) |-> (!busy && !wrValid));

  assert_pop_is_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    fifoPop |-> (wrValid && wrReady && fifoValid));

endmodule

// File: tb/tb_sg_dma_engine.sv
`timescale 1ns/1ps
module tb_sg_dma_engine;

  logic        clk = 1'b0;
  logic        rstN;
  logic        cfgStart, cfgStop, cfgChainMode, trigIn;
  logic [31:0] cfgHeadPtr;
  logic [63:0] cfgBlkAddr;
  logic [31:0] cfgBlkLen;
  logic        fifoValid;
  logic [31:0] fifoData;
  logic        fifoPop;
  logic        rdReqValid;
  logic [31:0] rdReqAddr;
  logic        rdReqReady;
  logic        rdRspValid;
  logic [31:0] rdRspData;
  logic        wrValid;
  logic [63:0] wrAddr;
  logic [31:0] wrData;
  logic        wrReady;
  logic        busy, doneFlag, errFlag;

  sg_dma_engine dut (.*);

  always #2 clk = ~clk;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  int wrCount = 0;
  int expSeq = 0;
  int srcCnt = 0;
  logic        stallMode = 1'b0;
  logic [15:0] lfsr;
  logic [63:0] expAddrQ[$];
  logic [31:0] expDataQ[$];
  logic [31:0] rdExpQ[$];
  logic [31:0] mem [logic [31:0]];

  function automatic logic [31:0] srcWord(input int n);
    return 32'hC0DE_0000 ^ 32'(n);
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // stall pattern, staging FIFO source and descriptor memory
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (!rstN) lfsr <= 16'hACE1;
    else       lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (!rstN)        srcCnt <= 0;
    else if (fifoPop) srcCnt <= srcCnt + 1;
    rdRspValid <= 1'b0;
    if (rstN && rdReqValid && rdReqReady) begin
      rdRspValid <= 1'b1;
      rdRspData  <= mem.exists(rdReqAddr) ? mem[rdReqAddr] : 32'hDEAD_BEEF;
    end
  end
  assign fifoValid  = !stallMode || lfsr[0];
  assign wrReady    = !stallMode || lfsr[3];
  assign rdReqReady = !stallMode || lfsr[5];
  assign fifoData   = srcWord(srcCnt);

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN) begin
      if (wrValid && wrReady) begin
        wrCount++;
        if (expAddrQ.size() == 0) check(1'b0, "R10 R11 unexpected write", wrAddr, 64'h0);
        else begin
          logic [63:0] ea;
          logic [31:0] ed;
          ea = expAddrQ.pop_front();
          ed = expDataQ.pop_front();
          check(wrAddr == ea, "R3 R9 write address", wrAddr, ea);
          check(wrData == ed, "R3 R9 write data", {32'h0, wrData}, {32'h0, ed});
        end
      end
      if (rdReqValid && rdReqReady) begin
        if (rdExpQ.size() == 0) check(1'b0, "R6 unexpected read", {32'h0, rdReqAddr}, 64'h0);
        else begin
          logic [31:0] ra;
          ra = rdExpQ.pop_front();
          check(rdReqAddr == ra, "R6 read order", {32'h0, rdReqAddr}, {32'h0, ra});
        end
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic expectBlock(input logic [63:0] addr, input int n);
    for (int i = 0; i < n; i++) begin
      expAddrQ.push_back(addr + 64'(4 * i));
      expDataQ.push_back(srcWord(expSeq));
      expSeq++;
    end
  endtask

  task automatic expectFetch(input logic [31:0] ptr);
    for (int i = 0; i < 4; i++) rdExpQ.push_back(ptr + 32'(4 * i));
  endtask

  task automatic putDesc(input logic [31:0] ptr, input logic [63:0] addr,
                         input logic [31:0] size, input logic [31:0] nxt);
    mem[ptr]      = addr[31:0];
    mem[ptr + 4]  = addr[63:32];
    mem[ptr + 8]  = size;
    mem[ptr + 12] = nxt;
  endtask

  task automatic pulseStart(input logic chain, input logic [31:0] head,
                            input logic [63:0] addr, input logic [31:0] len);
    cfgChainMode = chain; cfgHeadPtr = head; cfgBlkAddr = addr; cfgBlkLen = len;
    cfgStart = 1'b1; step(); cfgStart = 1'b0;
  endtask

  task automatic pulseTrig();
    trigIn = 1'b1; step(); trigIn = 1'b0;
  endtask

  task automatic pulseStop();
    cfgStop = 1'b1; step(); cfgStop = 1'b0;
  endtask

  task automatic waitIdle(input string req);
    int n = 0;
    while (busy && n < 20000) begin step(); n++; end
    check(!busy, req, {63'h0, busy}, 64'h0);
  endtask

  task automatic queuesEmpty(input string req);
    check(expAddrQ.size() == 0, req, 64'(expAddrQ.size()), 64'h0);
    check(rdExpQ.size() == 0, req, 64'(rdExpQ.size()), 64'h0);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      summary();
    end
  end

  initial begin
    int base;
    rstN = 1'b0; cfgStart = 1'b0; cfgStop = 1'b0; trigIn = 1'b0;
    cfgChainMode = 1'b0; cfgHeadPtr = '0; cfgBlkAddr = '0; cfgBlkLen = '0;
    repeat (3) step();
    check({busy, doneFlag, errFlag, wrValid, rdReqValid, fifoPop} == 6'b0, "R1 in reset",
          {58'h0, busy, doneFlag, errFlag, wrValid, rdReqValid, fifoPop}, 64'h0);
    rstN = 1'b1;
    step();
    check({busy, doneFlag, errFlag, wrValid, rdReqValid, fifoPop} == 6'b0, "R1 after reset",
          {58'h0, busy, doneFlag, errFlag, wrValid, rdReqValid, fifoPop}, 64'h0);

    // single block, trigger held back (R2, R3)
    expectBlock(64'h0000_0001_0000_1000, 5);
    pulseStart(1'b0, 32'h0, 64'h0000_0001_0000_1000, 32'd5);
    repeat (8) step();
    check(busy == 1'b1, "R2 armed busy", {63'h0, busy}, 64'h1);
    check(wrCount == 0 && !wrValid, "R2 no write before trigger", 64'(wrCount), 64'h0);
    pulseTrig();
    waitIdle("R3 single finishes");
    check(doneFlag == 1'b1 && errFlag == 1'b0, "R3 done set", {62'h0, doneFlag, errFlag}, 64'h2);
    queuesEmpty("R3 all words written");

    // zero length (R5)
    base = wrCount;
    pulseStart(1'b0, 32'h0, 64'h7000, 32'd0);
    waitIdle("R5 zero length idle");
    check(doneFlag == 1'b1, "R5 done on zero length", {63'h0, doneFlag}, 64'h1);
    check(wrCount == base, "R5 no write", 64'(wrCount), 64'(base));

    // oversize and cap (R4, R12)
    pulseStart(1'b0, 32'h0, 64'h8000, 32'd2097153);
    check(errFlag == 1'b1 && busy == 1'b0, "R4 oversize error", {62'h0, errFlag, busy}, 64'h2);
    check(doneFlag == 1'b0, "R12 done cleared by start", {63'h0, doneFlag}, 64'h0);
    step();
    check(errFlag == 1'b1, "R12 error sticky", {63'h0, errFlag}, 64'h1);
    pulseStart(1'b0, 32'h0, 64'h8000, 32'd2097152);
    check(errFlag == 1'b0 && busy == 1'b1, "R4 cap length accepted", {62'h0, errFlag, busy}, 64'h1);
    pulseStop();
    waitIdle("R10 stop while armed");
    check(doneFlag == 1'b1, "R10 done after stop", {63'h0, doneFlag}, 64'h1);

    // start while busy is ignored (R11)
    expectBlock(64'h5000, 3);
    pulseStart(1'b0, 32'h0, 64'h5000, 32'd3);
    step();
    pulseStart(1'b0, 32'h0, 64'h9000, 32'd7);
    pulseTrig();
    waitIdle("R11 first run finishes");
    queuesEmpty("R11 second start ignored");

    // chain with zero-size link, 4 GB crossing, random stalls (R6 R7 R8 R9)
    stallMode = 1'b1;
    putDesc(32'h400, 64'h0000_0001_0000_0040, 32'd4, 32'h500);
    putDesc(32'h500, 64'h0000_0000_DEAD_0000, 32'd0, 32'h600);
    putDesc(32'h600, 64'h0000_0002_FFFF_FFF8, 32'd3, 32'h0);
    expectFetch(32'h400); expectBlock(64'h0000_0001_0000_0040, 4);
    expectFetch(32'h500);
    expectFetch(32'h600); expectBlock(64'h0000_0002_FFFF_FFF8, 3);
    pulseStart(1'b1, 32'h400, 64'h0, 32'h0);
    repeat (5) step();
    check(!rdReqValid, "R2 no fetch before trigger", {63'h0, rdReqValid}, 64'h0);
    pulseTrig();
    waitIdle("R7 chain finishes");
    check(doneFlag == 1'b1, "R7 done at null link", {63'h0, doneFlag}, 64'h1);
    queuesEmpty("R8 R9 chain words and fetches");
    stallMode = 1'b0;

    // circular ring stopped after several laps (R10)
    putDesc(32'h100, 64'h2000, 32'd2, 32'h200);
    putDesc(32'h200, 64'h3000, 32'd3, 32'h100);
    for (int lap = 0; lap < 4; lap++) begin
      expectFetch(32'h100); expectBlock(64'h2000, 2);
      expectFetch(32'h200); expectBlock(64'h3000, 3);
    end
    base = wrCount;
    pulseStart(1'b1, 32'h100, 64'h0, 32'h0);
    pulseTrig();
    for (int n = 0; n < 2000 && (wrCount - base) < 12; n++) step();
    pulseStop();
    waitIdle("R10 ring stops");
    check(doneFlag == 1'b1, "R10 done after ring stop", {63'h0, doneFlag}, 64'h1);
    check((wrCount - base) >= 12 && (wrCount - base) <= 20, "R10 ring wrapped",
          64'(wrCount - base), 64'd12);
    expAddrQ.delete(); expDataQ.delete(); rdExpQ.delete();
    expSeq = srcCnt;
    base = wrCount;
    repeat (30) step();
    check(wrCount == base, "R10 no write after stop", 64'(wrCount), 64'(base));

    summary();
  end

endmodule